// File: doc/BRIEF.md
# Shared-Bus Port Controller with Mailbox Bypass

This block is the clocked control for one side of a pair of FIFOs that carry data in opposite directions. A single 18-bit bus serves both directions. On each rising clock edge, a read/write select, an active-low enable and an active-low output enable decide what happens. In a write cycle, the word on the bus is taken into an input holding register and handed to the outgoing FIFO. In a read cycle, the output register is loaded from the incoming FIFO. The FIFO storage, the flag logic and the opposite port sit outside this block.

A 3-bit address picks the path. Code 001 selects a mailbox bypass. In that mode, a write sends the bus word straight to the opposite direction's output register, and a read loads this side's output register from the mailbox word. Every other code uses the FIFO path.

The bus tri-state is modelled as a data-out and drive-enable pair. The drive-enable comes from a register, so it changes only on a clock edge. The block flags two errors. One is a write attempted just after a cycle in which the bus was driven. The other is a write to a full FIFO.

Top module: `portctl_top`

## Requirements
- R1: During and right after reset, `busOe`, `busOut`, `inHold`, `protoErr` and `ovfErr` are all zero. No read or write strobe is active while no cycle is requested.
- R2: A write cycle that is legal, not full and on the FIFO path asserts `fifoWrEn` in that cycle, with `wrData` equal to `busIn`. A write cycle means `rwSel`=0 and `enN`=0. The FIFO path means any address except 001, for example 000, 100 or 111. After the edge, `inHold` equals the captured word.
- R3: With `enN`=1, no strobe is asserted. `inHold` and `busOut` keep their values whatever the address or bus data.
- R4: A read cycle (`rwSel`=1, `enN`=0) on the FIFO path with the FIFO not empty asserts `fifoRdEn`. It loads `fifoRdData` into the output register on the edge. This happens whether `oeN` is high or low.
- R5: A read cycle on the FIFO path while `fifoEmpty`=1 leaves `fifoRdEn` low and leaves `busOut` unchanged.
- R6: After each edge, `busOe` is 1 exactly when the sampled `rwSel` was 1 and `oeN` was 0. A sampled `rwSel`=0 gives `busOe`=0 even with `oeN`=0. `busOut` always shows the output register.
- R7: A read cycle with address 001 loads `bypassIn` into the output register. It does not assert `fifoRdEn`, even when the FIFO is not empty.
- R8: A legal write cycle with address 001 asserts `bypassXfer` with `wrData`=`busIn`. It asserts no `fifoWrEn` and still captures the word into `inHold`.
- R9: A write cycle while `busOe`=1 is a protocol error. It asserts no write strobe and leaves `inHold` unchanged. `protoErr` is high for exactly the one cycle after that edge.
- R10: A FIFO-path write while `fifoFull`=1 is dropped: no `fifoWrEn`, and `inHold` is unchanged. `ovfErr` is high for exactly the one cycle after that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rstN | input | 1 | Asynchronous reset, active low |
| rwSel | input | 1 | 1 = read cycle, 0 = write cycle |
| enN | input | 1 | Cycle enable, active low |
| oeN | input | 1 | Bus output enable, active low |
| addr | input | 3 | Path select; 001 = mailbox bypass |
| busIn | input | 18 | Word present on the shared bus |
| busOut | output | 18 | Output register, driven onto the bus |
| busOe | output | 1 | Registered bus drive enable |
| fifoWrEn | output | 1 | Write strobe to the outgoing FIFO |
| wrData | output | 18 | Write word for the FIFO or the mailbox |
| fifoFull | input | 1 | Outgoing FIFO is full |
| fifoRdEn | output | 1 | Read pointer advance for the incoming FIFO |
| fifoRdData | input | 18 | Head word of the incoming FIFO |
| fifoEmpty | input | 1 | Incoming FIFO is empty |
| bypassXfer | output | 1 | Moves `wrData` into the opposite output register |
| bypassIn | input | 18 | Mailbox word from the opposite side |
| inHold | output | 18 | Input holding register |
| protoErr | output | 1 | One-cycle pulse: write right after a driven-bus cycle |
| ovfErr | output | 1 | One-cycle pulse: write to a full FIFO |

## Verification
The hardest case to reach is the write that follows a driven-bus cycle. The drive enable is registered, so the stimulus first has to run a read cycle with `oeN` low. Only then, on the very next edge, can it present a write. The vector table chains a read with the bus floating, an empty read with the bus driven, and an idle driven cycle before the illegal write. It then checks that the write is blocked, that the error pulse lasts one cycle, and that the drive enable falls. A full-FIFO write and a mailbox transfer come straight after, so the bench also confirms that the error pulses do not linger.

// File: rtl/portctl_pkg.sv
package portctl_pkg;
  // Strobes from the control half to the datapath half
  typedef struct packed {
    logic captureIn;   // take busIn into the input holding register
    logic loadFifo;    // load output register from incoming FIFO head
    logic loadBypass;  // load output register from the mailbox word
  } dpStrobe_t;
endpackage

// File: rtl/portctl_ctrl.sv
module portctl_ctrl
  import portctl_pkg::*;
#(
  parameter int ADDR_W      = 3,
  parameter int BYPASS_CODE = 1
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              rwSel,
  input  logic              enN,
  input  logic              oeN,
  input  logic [ADDR_W-1:0] addr,
  input  logic              fifoFull,
  input  logic              fifoEmpty,
  output logic              busOe,
  output logic              fifoWrEn,
  output logic              fifoRdEn,
  output logic              bypassXfer,
  output logic              protoErr,
  output logic              ovfErr,
  output dpStrobe_t         stb
);
  localparam logic [ADDR_W-1:0] BYP = ADDR_W'(BYPASS_CODE);

  logic wrReq, rdReq, bypassSel, wrLegal, wrBlocked, wrFullDrop;

  always_comb begin
    wrReq      = !rwSel && !enN;
    rdReq      = rwSel && !enN;
    bypassSel  = (addr == BYP);
    wrBlocked  = wrReq && busOe;
    wrLegal    = wrReq && !busOe;
    wrFullDrop = wrLegal && !bypassSel && fifoFull;
    fifoWrEn   = wrLegal && !bypassSel && !fifoFull;
    bypassXfer = wrLegal && bypassSel;
    fifoRdEn   = rdReq && !bypassSel && !fifoEmpty;
    stb.captureIn  = fifoWrEn || bypassXfer;
    stb.loadFifo   = fifoRdEn;
    stb.loadBypass = rdReq && bypassSel;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      busOe    <= 1'b0;
      protoErr <= 1'b0;
      ovfErr   <= 1'b0;
    end else begin
      busOe    <= rwSel && !oeN;
      protoErr <= wrBlocked;
      ovfErr   <= wrFullDrop;
    end
  end

  AST_DRIVE_SOURCE: assert property (@(posedge clk) disable iff (!rstN)
    busOe |-> $past(rwSel && !oeN)); // R6
  AST_WRITE_LOW_FLOATS: assert property (@(posedge clk) disable iff (!rstN)
    !rwSel |=> !busOe); // R6
  AST_NO_WRITE_AFTER_DRIVE: assert property (@(posedge clk) disable iff (!rstN)
    (busOe && !rwSel && !enN) |-> (!fifoWrEn && !bypassXfer) ##1 protoErr); // R9
  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rstN)
    fifoFull |-> !fifoWrEn); // R10
  AST_NO_UNDERFLOW: assert property (@(posedge clk) disable iff (!rstN)
    fifoEmpty |-> !fifoRdEn); // R5
  AST_ONE_STROBE: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({fifoWrEn, bypassXfer, fifoRdEn})); // R3
  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rstN)
    enN |-> !(fifoWrEn || bypassXfer || fifoRdEn)); // R3
endmodule

// File: rtl/portctl_dp.sv
module portctl_dp
  import portctl_pkg::*;
#(
  parameter int DATA_W = 18
) (
  input  logic              clk,
  input  logic              rstN,
  input  dpStrobe_t         stb,
  input  logic [DATA_W-1:0] busIn,
  input  logic [DATA_W-1:0] fifoRdData,
  input  logic [DATA_W-1:0] bypassIn,
  output logic [DATA_W-1:0] busOut,
  output logic [DATA_W-1:0] wrData,
  output logic [DATA_W-1:0] inHold
);
  logic [DATA_W-1:0] outReg;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      inHold <= '0;
      outReg <= '0;
    end else begin
      if (stb.captureIn) inHold <= busIn;
      if (stb.loadBypass) outReg <= bypassIn;
      else if (stb.loadFifo) outReg <= fifoRdData;
    end
  end

  assign busOut = outReg;
  assign wrData = busIn;

  AST_OUT_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    !(stb.loadFifo || stb.loadBypass) |=> $stable(outReg)); // R3
  AST_IN_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    !stb.captureIn |=> $stable(inHold)); // R9
  AST_CAPTURE: assert property (@(posedge clk) disable iff (!rstN)
    stb.captureIn |=> (inHold == $past(busIn))); // R2
endmodule

// File: rtl/portctl_top.sv
module portctl_top
  import portctl_pkg::*;
#(
  parameter int DATA_W      = 18,
  parameter int ADDR_W      = 3,
  parameter int BYPASS_CODE = 1
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              rwSel,
  input  logic              enN,
  input  logic              oeN,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] busIn,
  output logic [DATA_W-1:0] busOut,
  output logic              busOe,
  output logic              fifoWrEn,
  output logic [DATA_W-1:0] wrData,
  input  logic              fifoFull,
  output logic              fifoRdEn,
  input  logic [DATA_W-1:0] fifoRdData,
  input  logic              fifoEmpty,
  output logic              bypassXfer,
  input  logic [DATA_W-1:0] bypassIn,
  output logic [DATA_W-1:0] inHold,
  output logic              protoErr,
  output logic              ovfErr
);
  dpStrobe_t stb;

  portctl_ctrl #(.ADDR_W(ADDR_W), .BYPASS_CODE(BYPASS_CODE)) u_ctrl (
    .clk(clk), .rstN(rstN), .rwSel(rwSel), .enN(enN), .oeN(oeN), .addr(addr),
    .fifoFull(fifoFull), .fifoEmpty(fifoEmpty), .busOe(busOe),
    .fifoWrEn(fifoWrEn), .fifoRdEn(fifoRdEn), .bypassXfer(bypassXfer),
    .protoErr(protoErr), .ovfErr(ovfErr), .stb(stb)
  );

  portctl_dp #(.DATA_W(DATA_W)) u_dp (
    .clk(clk), .rstN(rstN), .stb(stb), .busIn(busIn), .fifoRdData(fifoRdData),
    .bypassIn(bypassIn), .busOut(busOut), .wrData(wrData), .inHold(inHold)
  );
endmodule

// File: tb/portctl_top_bench.sv
module portctl_top_bench;
  typedef struct packed {
    logic        rw, en, oe;
    logic [2:0]  ad;
    logic [17:0] din;
    logic        full, empty;
    logic [17:0] rd, byp;
    logic        eWr, eRd, eX;
    logic [17:0] eOut;
    logic        eOe;
    logic [17:0] eIn;
    logic        eProto, eOvf;
  } vec_t;

  localparam int NV = 13;
  localparam vec_t VECS [NV] = '{
    // rw en oe ad   din       full empty rd        byp       wr rd x  out       oe in        pe oe
    '{1'b0,1'b0,1'b1,3'd0,18'h00011,1'b0,1'b1,18'h0,18'h0,   1'b1,1'b0,1'b0,18'h0,    1'b0,18'h00011,1'b0,1'b0}, // R2
    '{1'b0,1'b0,1'b1,3'd4,18'h00022,1'b0,1'b1,18'h0,18'h0,   1'b1,1'b0,1'b0,18'h0,    1'b0,18'h00022,1'b0,1'b0}, // R2 code 100
    '{1'b0,1'b1,1'b1,3'd0,18'h00033,1'b0,1'b1,18'h0,18'h0,   1'b0,1'b0,1'b0,18'h0,    1'b0,18'h00022,1'b0,1'b0}, // R3
    '{1'b1,1'b0,1'b1,3'd0,18'h0,    1'b0,1'b0,18'h000AA,18'h0,1'b0,1'b1,1'b0,18'h000AA,1'b0,18'h00022,1'b0,1'b0}, // R4 floating
    '{1'b1,1'b0,1'b0,3'd0,18'h0,    1'b0,1'b1,18'h000BB,18'h0,1'b0,1'b0,1'b0,18'h000AA,1'b1,18'h00022,1'b0,1'b0}, // R5 R6
    '{1'b1,1'b1,1'b0,3'd1,18'h0,    1'b0,1'b0,18'h0,18'h000CC,1'b0,1'b0,1'b0,18'h000AA,1'b1,18'h00022,1'b0,1'b0}, // R3 bypass idle
    '{1'b0,1'b0,1'b0,3'd0,18'h00044,1'b0,1'b1,18'h0,18'h0,   1'b0,1'b0,1'b0,18'h000AA,1'b0,18'h00022,1'b1,1'b0}, // R9 R6
    '{1'b0,1'b0,1'b1,3'd0,18'h00055,1'b1,1'b1,18'h0,18'h0,   1'b0,1'b0,1'b0,18'h000AA,1'b0,18'h00022,1'b0,1'b1}, // R10
    '{1'b0,1'b0,1'b1,3'd7,18'h00066,1'b0,1'b1,18'h0,18'h0,   1'b1,1'b0,1'b0,18'h000AA,1'b0,18'h00066,1'b0,1'b0}, // R2 code 111
    '{1'b0,1'b0,1'b1,3'd1,18'h00077,1'b1,1'b1,18'h0,18'h0,   1'b0,1'b0,1'b1,18'h000AA,1'b0,18'h00077,1'b0,1'b0}, // R8
    '{1'b1,1'b0,1'b0,3'd1,18'h0,    1'b0,1'b0,18'h00099,18'h01234,1'b0,1'b0,1'b0,18'h01234,1'b1,18'h00077,1'b0,1'b0}, // R7
    '{1'b1,1'b0,1'b0,3'd7,18'h0,    1'b0,1'b0,18'h3FFFF,18'h0,1'b0,1'b1,1'b0,18'h3FFFF,1'b1,18'h00077,1'b0,1'b0}, // R4 code 111
    '{1'b1,1'b1,1'b1,3'd0,18'h0,    1'b0,1'b0,18'h0,18'h0,   1'b0,1'b0,1'b0,18'h3FFFF,1'b0,18'h00077,1'b0,1'b0}  // R6
  };

  logic clk = 1'b0, rstN = 1'b0;
  logic rwSel = 1'b1, enN = 1'b1, oeN = 1'b1;
  logic [2:0] addr = '0;
  logic [17:0] busIn = '0, fifoRdData = '0, bypassIn = '0;
  logic fifoFull = 1'b0, fifoEmpty = 1'b1;
  logic [17:0] busOut, wrData, inHold;
  logic busOe, fifoWrEn, fifoRdEn, bypassXfer, protoErr, ovfErr;
  int nChecks = 0, nFails = 0;
  bit finished = 0;

  always #2 clk = ~clk;

  portctl_top u_portctl_top (
    .clk(clk), .rstN(rstN), .rwSel(rwSel), .enN(enN), .oeN(oeN), .addr(addr),
    .busIn(busIn), .busOut(busOut), .busOe(busOe), .fifoWrEn(fifoWrEn),
    .wrData(wrData), .fifoFull(fifoFull), .fifoRdEn(fifoRdEn),
    .fifoRdData(fifoRdData), .fifoEmpty(fifoEmpty), .bypassXfer(bypassXfer),
    .bypassIn(bypassIn), .inHold(inHold), .protoErr(protoErr), .ovfErr(ovfErr)
  );

  task automatic check(input string req, input string what,
                       input logic [17:0] act, input logic [17:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic checkIdle(input string req);
    check(req, "busOe", 18'(busOe), 18'h0);
    check(req, "busOut", busOut, 18'h0);
    check(req, "inHold", inHold, 18'h0);
    check(req, "protoErr", 18'(protoErr), 18'h0);
    check(req, "ovfErr", 18'(ovfErr), 18'h0);
    check(req, "strobes", 18'({fifoWrEn, fifoRdEn, bypassXfer}), 18'h0);
  endtask

  initial begin
    #1;
    checkIdle("R1");
    repeat (3) @(posedge clk);
    @(negedge clk) rstN = 1'b1;
    @(negedge clk);
    checkIdle("R1");
    for (int i = 0; i < NV; i++) begin
      rwSel = VECS[i].rw; enN = VECS[i].en; oeN = VECS[i].oe; addr = VECS[i].ad;
      busIn = VECS[i].din; fifoFull = VECS[i].full; fifoEmpty = VECS[i].empty;
      fifoRdData = VECS[i].rd; bypassIn = VECS[i].byp;
      #1;
      check($sformatf("R2/R10 v%0d", i), "fifoWrEn", 18'(fifoWrEn), 18'(VECS[i].eWr));
      check($sformatf("R4/R5 v%0d", i), "fifoRdEn", 18'(fifoRdEn), 18'(VECS[i].eRd));
      check($sformatf("R8 v%0d", i), "bypassXfer", 18'(bypassXfer), 18'(VECS[i].eX));
      check($sformatf("R2 v%0d", i), "wrData", wrData, VECS[i].din);
      @(posedge clk); #1;
      check($sformatf("R4/R7 v%0d", i), "busOut", busOut, VECS[i].eOut);
      check($sformatf("R6 v%0d", i), "busOe", 18'(busOe), 18'(VECS[i].eOe));
      check($sformatf("R3/R9 v%0d", i), "inHold", inHold, VECS[i].eIn);
      check($sformatf("R9 v%0d", i), "protoErr", 18'(protoErr), 18'(VECS[i].eProto));
      check($sformatf("R10 v%0d", i), "ovfErr", 18'(ovfErr), 18'(VECS[i].eOvf));
      @(negedge clk);
    end
    // R9: error pulse lasts one cycle; drive bus then write twice
    rwSel = 1'b1; enN = 1'b1; oeN = 1'b0; fifoFull = 1'b0;
    @(negedge clk);
    rwSel = 1'b0; enN = 1'b0; addr = 3'd0; busIn = 18'h00ABC;
    @(posedge clk); #1;
    check("R9", "protoErr pulse", 18'(protoErr), 18'h1);
    @(posedge clk); #1;
    check("R9", "protoErr cleared", 18'(protoErr), 18'h0);
    check("R2", "inHold after legal retry", inHold, 18'h00ABC);
    // R1: reset mid-operation clears everything
    @(negedge clk);
    rwSel = 1'b1; enN = 1'b1; oeN = 1'b0;
    @(negedge clk) rstN = 1'b0;
    #1;
    oeN = 1'b1;
    checkIdle("R1");
    finished = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!finished) begin
      nChecks++; nFails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
      $finish;
    end
  end
endmodule